// File: doc/BRIEF.md
# Multichannel Interrupt Multiplexer

The block routes a shared bundle of 32 active-high, level-sensitive interrupt sources onto eight independent interrupt outputs. Each output belongs to one channel. Each channel keeps its own 32-bit enable mask and has its own pending view. Any source can be enabled in any number of channels at once. Each channel therefore selects its own subset of the shared sources and forwards them as a single request line to a downstream interrupt controller.

Software reaches the masks through a small 32-bit register bus with an APB-like access phase. The registers sit at a fixed stride of 0x40 bytes per channel. The enable mask of a channel can be read back, so single bits can be changed by read-modify-write. The pending view is read-only and shows the live AND of sources and mask. Each channel output is registered. It follows the OR of that channel's pending bits with one clock of delay and is never latched.

Top module: `irq_fanout_mux`

## Requirements
- R1: After reset every enable mask reads 0 and every channel output is low.
- R2: The enable mask of channel n is at byte offset 0x10 + 0x40*n, where bit k enables source k. A read of that offset returns the last value written.
- R3: The pending view of channel n is at byte offset 0x20 + 0x40*n. Bit k reads 1 exactly when source k is high and enable bit k of channel n is set. The read data reflects source and mask changes in the same cycle, with no register in between.
- R4: A channel output goes high one clock edge after any of its pending bits becomes 1. It goes low one clock edge after all of its pending bits become 0, so it holds nothing once the sources fall.
- R5: All channels observe the same source lines. A source enabled in several channels drives each of their outputs, and a channel with that source masked stays low.
- R6: Writing 0 to a channel's enable mask clears all of its bits, and that channel's output is low one edge after the write commits.
- R7: Writes to pending offsets, to unmapped offsets inside a channel window and to windows beyond the last channel leave all masks unchanged. Reads of unmapped offsets return 0.
- R8: A write commits only on a clock edge where select, access and write are all high. A write cycle with access low changes no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 32 | Shared level interrupt sources, active high |
| bus_sel_i | input | 1 | Register bus select |
| bus_access_i | input | 1 | Register bus access phase |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| chan_irq_o | output | 8 | Registered interrupt output per channel |

## Verification
A mask write and a source transition can fall into the same cycle. The registered output then has to use the mask that was in place at the committing edge, and the new mask only from the following edge. The bench provokes this by writing a channel's mask while it raises a newly enabled source in that same cycle. It expects the output to stay low at the commit edge while the pending read already shows the bit, and to rise one edge later. A pending read in the cycle a source falls is also judged against the live source value.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  typedef enum logic [1:0] {
    FLD_NONE    = 2'd0,
    FLD_ENABLE  = 2'd1,
    FLD_PENDING = 2'd2
  } irqmux_fld_e;
endpackage

// File: rtl/irqmux_decode.sv
module irqmux_decode
  import irqmux_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 12,
  parameter int STRIDE   = 64,
  parameter int EN_OFS   = 16,
  parameter int PEND_OFS = 32,
  localparam int STR_LSB = $clog2(STRIDE),
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output irqmux_fld_e       fld_o,
  output logic [CH_W-1:0]   ch_o
);
  logic [ADDR_W-1:0]  window;
  logic [STR_LSB-1:0] offs;
  logic               in_range;

  always_comb begin
    window   = addr_i >> STR_LSB;
    offs     = addr_i[STR_LSB-1:0];
    in_range = (window < ADDR_W'(NUM_CH));
    ch_o     = window[CH_W-1:0];
    fld_o    = FLD_NONE;
    if (in_range) begin
      if (offs == STR_LSB'(EN_OFS))        fld_o = FLD_ENABLE;
      else if (offs == STR_LSB'(PEND_OFS)) fld_o = FLD_PENDING;
    end
  end
endmodule

// File: rtl/irqmux_channel.sv
module irqmux_channel #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] en_q;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (wr_en_i) en_q <= wdata_i;
  end

  assign pend_o = src_i & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_o;
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (en_q == $past(wdata_i)));                       // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(en_q));                                 // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(pend_o != '0));                       // R4
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    $past(pend_o == '0) |-> !irq_q);                             // R4
  AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(en_q == '0) |-> !irq_q);                               // R6
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
  import irqmux_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 12,
  parameter int STRIDE   = 64,
  parameter int EN_OFS   = 16,
  parameter int PEND_OFS = 32,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_sel_i,
  input  logic               bus_access_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [NUM_SRC-1:0] bus_wdata_i,
  output logic [NUM_SRC-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0]  chan_irq_o
);
  irqmux_fld_e                      fld;
  logic [CH_W-1:0]                  ch_sel;
  logic                             bus_we;
  logic [NUM_CH-1:0][NUM_SRC-1:0]   en_all;
  logic [NUM_CH-1:0][NUM_SRC-1:0]   pend_all;

  irqmux_decode #(
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .STRIDE  (STRIDE),
    .EN_OFS  (EN_OFS),
    .PEND_OFS(PEND_OFS)
  ) u_decode (
    .addr_i(bus_addr_i),
    .fld_o (fld),
    .ch_o  (ch_sel)
  );

  assign bus_we = bus_sel_i & bus_access_i & bus_write_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic wr_hit;
    assign wr_hit = bus_we && (fld == FLD_ENABLE) && (ch_sel == CH_W'(c));
    irqmux_channel #(.NUM_SRC(NUM_SRC)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .src_i  (irq_src_i),
      .wr_en_i(wr_hit),
      .wdata_i(bus_wdata_i),
      .en_o   (en_all[c]),
      .pend_o (pend_all[c]),
      .irq_o  (chan_irq_o[c])
    );
  end

  always_comb begin
    unique case (fld)
      FLD_ENABLE:  bus_rdata_o = en_all[ch_sel];
      FLD_PENDING: bus_rdata_o = pend_all[ch_sel];
      default:     bus_rdata_o = '0;
    endcase
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fld == FLD_NONE) |-> (bus_rdata_o == '0));                  // R7
  AST_PEND_WITHIN_SRC: assert property (@(posedge clk) disable iff (rst)
    (fld == FLD_PENDING) |-> ((bus_rdata_o & ~irq_src_i) == '0)); // R3
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_access_i |=> $stable(en_all));                          // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (chan_irq_o == '0));                          // R1
endmodule

// File: tb/irq_fanout_mux_tb.sv
module irq_fanout_mux_tb;
  localparam int NCH = 8;
  localparam int NS  = 32;
  localparam int AW  = 12;

  logic           clk = 1'b0;
  logic           rst;
  logic [NS-1:0]  src;
  logic           sel, access, write;
  logic [AW-1:0]  addr;
  logic [NS-1:0]  wdata;
  logic [NS-1:0]  rdata;
  logic [NCH-1:0] irq;

  int checks   = 0;
  int failures = 0;
  logic [NS-1:0] exp_en [NCH];

  always #10 clk = ~clk;

  irq_fanout_mux u_dut (
    .clk(clk), .rst(rst), .irq_src_i(src),
    .bus_sel_i(sel), .bus_access_i(access), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .chan_irq_o(irq)
  );

  function automatic logic [AW-1:0] en_addr(int c);
    return AW'(16 + 64 * c);
  endfunction
  function automatic logic [AW-1:0] pd_addr(int c);
    return AW'(32 + 64 * c);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [NS-1:0] d, logic acc);
    @(negedge clk);
    sel = 1'b1; access = acc; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; access = 1'b0; write = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [NS-1:0] d);
    @(negedge clk);
    sel = 1'b1; access = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [NCH-1:0] exp_irq();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = |(src & exp_en[c]);
    return r;
  endfunction

  task automatic t_reset();
    logic [NS-1:0] d;
    chk("R1 irq after reset", 32'(irq), 32'h0);
    for (int c = 0; c < NCH; c++) begin
      bus_read(en_addr(c), d);
      chk("R1 enable after reset", d, 32'h0);
    end
  endtask

  task automatic t_enable_rw();
    logic [NS-1:0] d;
    for (int c = 0; c < NCH; c++) begin
      exp_en[c] = 32'hA5000000 ^ (32'h01010101 << c) ^ 32'(c);
      bus_write(en_addr(c), exp_en[c], 1'b1);
    end
    for (int c = 0; c < NCH; c++) begin
      bus_read(en_addr(c), d);
      chk("R2 enable readback", d, exp_en[c]);
    end
    exp_en[2] = exp_en[2] | 32'h0000_8000;
    bus_read(en_addr(2), d);
    bus_write(en_addr(2), d | 32'h0000_8000, 1'b1);
    bus_read(en_addr(2), d);
    chk("R2 read-modify-write", d, exp_en[2]);
  endtask

  task automatic t_pending_view();
    logic [NS-1:0] d;
    @(negedge clk);
    src = 32'hF0F0_1234;
    for (int c = 0; c < NCH; c++) begin
      bus_read(pd_addr(c), d);
      chk("R3 pending value", d, src & exp_en[c]);
    end
    @(negedge clk);
    sel = 1'b1; access = 1'b1; write = 1'b0; addr = pd_addr(5);
    src = 32'h0;
    #1 chk("R3 pending same cycle", rdata, 32'h0);
  endtask

  task automatic t_output_timing();
    for (int c = 0; c < NCH; c++) exp_en[c] = 32'h0;
    exp_en[1] = 32'h0000_0010;
    bus_write(en_addr(1), exp_en[1], 1'b1);
    for (int c = 0; c < NCH; c++) if (c != 1) bus_write(en_addr(c), 32'h0, 1'b1);
    @(negedge clk);
    src = 32'h0000_0010;
    #1 chk("R4 no rise before edge", 32'(irq[1]), 32'h0);
    @(negedge clk);
    chk("R4 rise after one edge", 32'(irq), 32'(exp_irq()));
    @(negedge clk);
    src = 32'h0;
    #1 chk("R4 held until edge", 32'(irq[1]), 32'h1);
    @(negedge clk);
    chk("R4 drop not latched", 32'(irq), 32'h0);
  endtask

  task automatic t_shared();
    exp_en[0] = 32'h0000_0100;
    exp_en[3] = 32'h0000_0100;
    exp_en[6] = 32'h0000_0100;
    exp_en[1] = 32'h0;
    bus_write(en_addr(0), exp_en[0], 1'b1);
    bus_write(en_addr(3), exp_en[3], 1'b1);
    bus_write(en_addr(6), exp_en[6], 1'b1);
    bus_write(en_addr(1), exp_en[1], 1'b1);
    @(negedge clk);
    src = 32'h0000_0100;
    @(negedge clk);
    chk("R5 shared source fan-out", 32'(irq), 32'h49);
    chk("R5 model agreement", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic t_clear();
    logic [NS-1:0] d;
    exp_en[3] = 32'h0;
    bus_write(en_addr(3), 32'h0, 1'b1);
    bus_read(en_addr(3), d);
    chk("R6 cleared mask", d, 32'h0);
    chk("R6 channel output low", 32'(irq), 32'h41);
  endtask

  task automatic t_ignored();
    logic [NS-1:0] d;
    bus_write(pd_addr(0), 32'hFFFF_FFFF, 1'b1);
    bus_write(AW'(12'h014), 32'hFFFF_FFFF, 1'b1);
    bus_write(AW'(12'h000), 32'hFFFF_FFFF, 1'b1);
    bus_write(AW'(12'h210), 32'hFFFF_FFFF, 1'b1);
    bus_write(AW'(12'h3D0), 32'hFFFF_FFFF, 1'b1);
    for (int c = 0; c < NCH; c++) begin
      bus_read(en_addr(c), d);
      chk("R7 mask untouched", d, exp_en[c]);
    end
    bus_read(AW'(12'h014), d);
    chk("R7 unmapped read", d, 32'h0);
    bus_read(AW'(12'h210), d);
    chk("R7 beyond last channel", d, 32'h0);
    bus_read(AW'(12'h000), d);
    chk("R7 window start read", d, 32'h0);
  endtask

  task automatic t_access_phase();
    logic [NS-1:0] d;
    bus_write(en_addr(4), 32'hDEAD_BEEF, 1'b0);
    bus_read(en_addr(4), d);
    chk("R8 setup-only write ignored", d, exp_en[4]);
    @(negedge clk);
    sel = 1'b0; access = 1'b1; write = 1'b1; addr = en_addr(4); wdata = 32'h1;
    @(negedge clk);
    access = 1'b0; write = 1'b0;
    bus_read(en_addr(4), d);
    chk("R8 unselected write ignored", d, exp_en[4]);
  endtask

  task automatic t_same_cycle();
    logic [NS-1:0] d;
    src = 32'h0;
    @(negedge clk);
    sel = 1'b1; access = 1'b1; write = 1'b1; addr = en_addr(5);
    wdata = 32'h0000_0020; src = 32'h0000_0020;
    exp_en[5] = 32'h0000_0020;
    @(negedge clk);
    sel = 1'b0; access = 1'b0; write = 1'b0;
    chk("R4 old mask at commit edge", 32'(irq[5]), 32'h0);
    sel = 1'b1; access = 1'b1; addr = pd_addr(5);
    #1 d = rdata;
    chk("R3 pending after commit", d, 32'h0000_0020);
    @(negedge clk);
    chk("R4 new mask one edge later", 32'(irq[5]), 32'h1);
    sel = 1'b0; access = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; src = '0; sel = 1'b0; access = 1'b0; write = 1'b0;
    addr = '0; wdata = '0;
    for (int c = 0; c < NCH; c++) exp_en[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable_rw();
    t_pending_view();
    t_output_timing();
    t_shared();
    t_clear();
    t_ignored();
    t_access_phase();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule